// File: doc/BRIEF.md
# Leading-One Length Encoder

This block takes a wide data word and reports its effective length. The effective length is the bit position of the highest set bit plus one, which is the same as the width minus the number of leading zeros. As an example, the 8-bit pattern 00011010 has an effective length of 5. If every bit of the word is zero, the length is 0 and a separate flag is raised.

The logic is a tree of small 4-input priority-encoder cells. The leaf cells each look at one nibble of the data. Every higher cell chooses the highest of its four children that holds a set bit. Each level therefore adds two index bits, and the depth of the logic grows with log4 of the width rather than with the width itself. Widths of 1024 bits and above need no change to the structure.

The block is purely combinational and has no clock. Its results follow the data input within the same evaluation step. The width parameter must be a power of four, 4 or larger.

Top module: `lead_len_enc`

## Requirements
- R1: When at least one data bit is set, `len_o` equals the position of the most significant set bit plus one, with bit 0 as the least significant bit.
- R2: When every data bit is zero, `len_o` is 0 and `zero_o` is 1.
- R3: `zero_o` is 0 whenever any data bit is set.
- R4: `len_o` is `$clog2(WIDTH)+1` bits wide, so that when only the top bit (WIDTH-1) is set it reads exactly WIDTH.
- R5: Bits below the leading one have no effect on `len_o`.
- R6: `len_o` and `zero_o` are pure combinational functions of `data_i`. They settle in the same step as the input changes and hold no state.
- R7: Inside each 4-bit group, the highest set bit decides the group's local index (index 3 for bit 3, down to index 0 for bit 0).
- R8: When more than one 4-bit group, or more than one higher-level group, holds a set bit, the group with the higher bit positions decides the length.
- R9: `len_o` never exceeds WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be measured |
| len_o | output | $clog2(WIDTH)+1 | Effective length: position of the top set bit plus one, or 0 |
| zero_o | output | 1 | High when data_i has no set bit |

## Verification
Both results are combinational, so each one is due in the same cycle that its stimulus is applied. The bench changes `data_i` on the falling edge of its pacing clock. It reads `len_o` and `zero_o` at the next rising edge, half a period later, when the whole tree has settled, and compares them with a plain top-down scan model. The assertions in the RTL are immediate. They are evaluated whenever the data changes, and they are skipped while the input still carries unknown values.

// File: rtl/lle_pkg.sv
package lle_pkg;

  // Local two-bit index of the highest set bit in a nibble (0 when empty).
  function automatic logic [1:0] nib_top_index(input logic [3:0] nib);
    logic [1:0] r;
    if (nib[3])      r = 2'd3;
    else if (nib[2]) r = 2'd2;
    else if (nib[1]) r = 2'd1;
    else             r = 2'd0;
    return r;
  endfunction

  // Any bit of the nibble set.
  function automatic logic nib_any(input logic [3:0] nib);
    return nib[3] | nib[2] | nib[1] | nib[0];
  endfunction

  // Number of tree levels for a power-of-four width.
  function automatic int tree_levels(input int width);
    int n;
    n = 0;
    for (int w = width; w > 1; w = w / 4) n++;
    return n;
  endfunction

endpackage

// File: rtl/lle_cell4.sv
module lle_cell4
  import lle_pkg::*;
(
  input  logic [3:0] vec_i,
  output logic       valid_o,
  output logic [1:0] idx_o
);

  always_comb begin
    valid_o = nib_any(vec_i);
    idx_o   = nib_top_index(vec_i);
  end

  always_comb begin
    if (!$isunknown(vec_i)) begin
      // R7
      cell_top_bit_chk: assert (!valid_o || vec_i[idx_o])
        else $error("cell index does not point at a set bit");
      // R7
      cell_above_clear_chk: assert (!valid_o || ((vec_i >> idx_o) == 4'd1))
        else $error("cell has a set bit above its index");
      // R2
      cell_empty_chk: assert (valid_o || (vec_i == 4'd0))
        else $error("cell reports empty with bits set");
    end
  end

endmodule

// File: rtl/lle_tree.sv
module lle_tree
  import lle_pkg::*;
#(
  parameter int WIDTH = 1024,
  localparam int IW   = $clog2(WIDTH),
  localparam int LV   = tree_levels(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o
);

  for (genvar l = 0; l < LV; l++) begin : lvl
    localparam int CNT = WIDTH >> (2 * (l + 1));
    localparam int SW  = 2 * (l + 1);
    logic [CNT-1:0] v;
    logic [SW-1:0]  ix [CNT];

    for (genvar c = 0; c < CNT; c++) begin : node
      logic [3:0] cv;
      logic [1:0] sel;
      if (l == 0) begin : leaf
        assign cv    = data_i[4*c +: 4];
        assign ix[c] = sel;
      end else begin : inner
        assign cv    = lvl[l-1].v[4*c +: 4];
        assign ix[c] = {sel, lvl[l-1].ix[4*c + int'(sel)]};
      end
      lle_cell4 u_cell (
        .vec_i  (cv),
        .valid_o(v[c]),
        .idx_o  (sel)
      );
    end
  end

  assign valid_o = lvl[LV-1].v[0];
  assign idx_o   = lvl[LV-1].ix[0];

  always_comb begin
    if (!$isunknown(data_i)) begin
      // R3
      tree_valid_any_chk: assert (valid_o == (data_i != '0))
        else $error("tree valid disagrees with data");
      // R8
      tree_index_set_chk: assert (!valid_o || data_i[idx_o])
        else $error("tree index points at a clear bit");
    end
  end

endmodule

// File: rtl/lead_len_enc.sv
module lead_len_enc #(
  parameter int WIDTH = 1024,
  localparam int IW   = $clog2(WIDTH),
  localparam int LW   = IW + 1
) (
  input  logic [WIDTH-1:0] data_i,
  output logic [LW-1:0]    len_o,
  output logic             zero_o
);

  logic          any_set;
  logic [IW-1:0] top_idx;

  lle_tree #(.WIDTH(WIDTH)) u_tree (
    .data_i (data_i),
    .valid_o(any_set),
    .idx_o  (top_idx)
  );

  always_comb begin
    zero_o = !any_set;
    len_o  = any_set ? ({1'b0, top_idx} + LW'(1)) : '0;
  end

  always_comb begin
    if (!$isunknown(data_i)) begin
      // R1
      lead_bit_chk: assert (zero_o || data_i[len_o - LW'(1)])
        else $error("bit below length is not set");
      // R5
      upper_clear_chk: assert ((data_i >> len_o) == '0)
        else $error("set bit found at or above length");
      // R2
      zero_flag_chk: assert (zero_o == (data_i == '0))
        else $error("zero flag disagrees with data");
      // R2
      zero_len_chk: assert (zero_o == (len_o == '0))
        else $error("zero flag disagrees with length");
      // R9
      len_range_chk: assert (len_o <= LW'(WIDTH))
        else $error("length exceeds width");
    end
  end

endmodule

// File: tb/lead_len_enc_test.sv
module lead_len_enc_test;

  localparam int W      = 256;
  localparam int LW     = $clog2(W) + 1;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic [W-1:0]  data;
  logic [LW-1:0] len;
  logic          zero;
  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 0;

  always #(PERIOD/2) clk = ~clk;

  lead_len_enc #(.WIDTH(W)) uut (
    .data_i(data),
    .len_o (len),
    .zero_o(zero)
  );

  function automatic int model_len(input logic [W-1:0] d);
    for (int i = W - 1; i >= 0; i--)
      if (d[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] d;
    for (int k = 0; k < W / 32; k++) d[32*k +: 32] = $urandom;
    return d;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (data=%h)", tag, got, exp, data);
    end
  endtask

  // drive on falling edge, sample on the next rising edge
  task automatic apply(input logic [W-1:0] d, input string tag);
    int e;
    @(negedge clk);
    data = d;
    @(posedge clk);
    e = model_len(d);
    check({tag, " len"}, int'(len), e);
    check({tag, " zero"}, int'(zero), (e == 0) ? 1 : 0);
  endtask

  task automatic t_all_zero();
    apply('0, "R2 all-zero");
  endtask

  task automatic t_single_bits();
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] d;
      d = '0;
      d[i] = 1'b1;
      apply(d, "R1 single-bit");
    end
  endtask

  task automatic t_top_bit();
    logic [W-1:0] d;
    d = '0;
    d[W-1] = 1'b1;
    apply(d, "R4 top-bit");
    check("R4 width", int'(len), W);
    apply('1, "R9 all-ones");
  endtask

  task automatic t_low_noise();
    for (int p = 0; p < W; p += 7) begin
      logic [W-1:0] d;
      logic [W-1:0] base;
      d = rand_word();
      base = '0;
      base[p] = 1'b1;
      d = (d & ((base << 1) - 1)) | base;
      d = d & ((base << 1) - 1);
      apply(d, "R5 low-noise");
      check("R5 length fixed by top bit", int'(len), p + 1);
    end
  endtask

  task automatic t_nibble_priority();
    for (int v = 1; v < 16; v++) begin
      logic [W-1:0] d;
      d = '0;
      d[3:0] = 4'(v);
      apply(d, "R7 nibble priority");
    end
  endtask

  task automatic t_group_priority();
    logic [W-1:0] d;
    d = '0; d[3] = 1; d[4] = 1;
    apply(d, "R8 adjacent groups");
    d = '0; d[15] = 1; d[16] = 1; d[0] = 1;
    apply(d, "R8 sixteen boundary");
    d = '0; d[63] = 1; d[64] = 1;
    apply(d, "R8 upper subtree");
    d = '0; d[W-5] = 1; d[W/2] = 1; d[1] = 1;
    apply(d, "R8 far groups");
  endtask

  task automatic t_settle();
    logic [W-1:0] d;
    d = '0; d[100] = 1;
    @(negedge clk);
    data = d;
    #1;
    check("R6 same-step length", int'(len), 101);
    data = '0;
    #1;
    check("R6 same-step clear", int'(zero), 1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] d;
      int sh;
      d = rand_word();
      sh = int'($urandom % W);
      d = d >> sh;
      apply(d, "R1 random");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    data = '0;
    @(posedge clk);
    check("R2 initial len", int'(len), 0);
    check("R2 initial zero", int'(zero), 1);
    t_all_zero();
    t_single_bits();
    t_top_bit();
    t_low_noise();
    t_nibble_priority();
    t_group_priority();
    t_settle();
    t_random();
    t_all_zero();
    finish_run();
  end

endmodule